// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte-wide holding buffer between a host register port and the bus side of a storage controller during programmed-I/O transfers. Host writes push bytes and host reads pop them. Each successful pop returns the next byte and sends a one-cycle interrupt request. At the end of a command, a response-load request puts a status byte and a zero message byte into the buffer, where the host reads them like any other data.

While a select-and-stop style command waits for its command bytes, a capture-mode input sends host writes to a separate command buffer instead of the data FIFO. That buffer keeps a length count, and the executing side reads it out by index. A fetch request ends the capture. It clears the command length and empties the data FIFO.

The data FIFO stops accepting writes one entry short of its depth. A write that arrives at that point is dropped and sets a sticky overrun flag.

Top module: `pio_byte_fifo`

## Requirements
- R1: A write while `capture_i` is high stores the byte at the command buffer position given by `cmd_len_o`, and `cmd_len_o` then increases by one. Occupancy and FIFO contents do not change.
- R2: A write while `capture_i` is low is dropped when the occupancy equals DEPTH-1 (default 15). Any other such write is stored and the occupancy increases by one.
- R3: A read with nonzero occupancy lowers the occupancy by one and updates `rd_data_o` with the oldest byte in the cycle after the strobe. `irq_o` is high for exactly that cycle. A read at zero occupancy changes nothing and raises no interrupt.
- R4: A read made while `dout_phase_i` is high still lowers the occupancy and raises `irq_o`, but it returns 0x00 and does not advance the read position.
- R5: When the occupancy reaches zero, both buffer positions return to entry 0. The next written byte is then the next byte read, even if earlier data-out reads left the positions unbalanced.
- R6: A response load makes the occupancy 2, and the next two reads return the status byte and then 0x00. It pulses `irq_o` in the following cycle and overrides any write or read in the same cycle.
- R7: A command fetch sets the occupancy and `cmd_len_o` to zero. It takes priority over writes, reads and response loads in the same cycle, and it raises no interrupt.
- R8: `overrun_o` goes high in the cycle after a dropped write and stays high until reset.
- R9: The command buffer holds CMD_DEPTH bytes (default 32). Once `cmd_len_o` equals CMD_DEPTH, further captured bytes are discarded. `cmd_byte_o` shows the stored byte at `cmd_idx_i`.
- R10: A read and a write in the same cycle both take effect, so a nonempty FIFO keeps its occupancy. The overrun test uses the occupancy from before the cycle, so at DEPTH-1 the write is still dropped and the occupancy becomes DEPTH-2.
- R11: After reset the occupancy, `cmd_len_o`, `rd_data_o`, `irq_o` and `overrun_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Byte returned by the most recent pop |
| capture_i | input | 1 | Send host writes to the command buffer |
| dout_phase_i | input | 1 | Bus is in a data-out phase; reads return zero |
| rsp_load_i | input | 1 | Load the status/message response |
| rsp_status_i | input | 8 | Status byte for the response |
| cmd_fetch_i | input | 1 | Hand over the command and empty both buffers |
| cmd_idx_i | input | 5 | Command buffer read index |
| cmd_byte_o | output | 8 | Command byte at `cmd_idx_i` |
| cmd_len_o | output | 6 | Number of captured command bytes |
| occupancy_o | output | 5 | Data FIFO occupancy |
| overrun_o | output | 1 | Sticky dropped-write flag |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
A push and a pop can happen in the same cycle, and this is the interaction most likely to go wrong. The bench produces it in two places. The first is a mid-stream read-plus-write, where the occupancy must stay the same while the oldest byte comes out. The second is a read-plus-write at the DEPTH-1 limit. There the overrun decision must use the occupancy from before the cycle, so the write is dropped, the flag is set and the occupancy falls by one. In both cases the bench compares the occupancy, the popped byte and the later drain order against values it works out from the requirements.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef logic [7:0] byte_t;
  localparam int    RSP_BYTES = 2;
  localparam byte_t MSG_FILL  = 8'h00;
endpackage

// File: rtl/pio_byte_ram.sv
module pio_byte_ram
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          we_a_i,
  input  logic [AW-1:0] addr_a_i,
  input  byte_t         data_a_i,
  input  logic          we_b_i,
  input  logic [AW-1:0] addr_b_i,
  input  byte_t         data_b_i,
  input  logic [AW-1:0] raddr_i,
  output byte_t         rdata_o
);
  logic [DEPTH-1:0][7:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    byte_t q;
    always_ff @(posedge clk_i) begin
      if (we_a_i && addr_a_i == AW'(g))      q <= data_a_i;
      else if (we_b_i && addr_b_i == AW'(g)) q <= data_b_i;
    end
    assign cells[g] = q;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture
  import pio_fifo_pkg::*;
#(
  parameter int CMD_DEPTH = 32,
  parameter int LEN_W     = 6,
  parameter int IDX_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             capture_i,
  input  logic             flush_i,
  input  byte_t            wr_data_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [LEN_W-1:0] len_o,
  output byte_t            byte_o
);
  logic [LEN_W-1:0] len_q;
  logic             take;
  logic [CMD_DEPTH-1:0][7:0] cells;

  assign take = wr_en_i && capture_i && !flush_i && (len_q < LEN_W'(CMD_DEPTH));

  for (genvar g = 0; g < CMD_DEPTH; g++) begin : g_cmd
    byte_t q;
    always_ff @(posedge clk_i) begin
      if (take && len_q == LEN_W'(g)) q <= wr_data_i;
    end
    assign cells[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (flush_i) len_q <= '0;
    else if (take)    len_q <= len_q + 1'b1;
  end

  assign len_o  = len_q;
  assign byte_o = cells[idx_i];
endmodule

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             capture_i,
  input  logic             dout_phase_i,
  input  logic             rsp_load_i,
  input  logic             flush_i,
  input  byte_t            ram_rdata_i,
  output logic             push_o,
  output logic             rsp_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [CNT_W-1:0] occ_o,
  output byte_t            rd_data_o,
  output logic             overrun_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] occ_q, occ_d;
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic             norm, at_limit, do_wr, do_rd, drop;
  logic             ovr_q, irq_q;
  byte_t            rd_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // fetch > response load > host strobes
  assign norm     = !flush_i && !rsp_load_i;
  assign at_limit = (occ_q == CNT_W'(DEPTH - 1));
  assign do_wr    = norm && wr_en_i && !capture_i && !at_limit;
  assign drop     = norm && wr_en_i && !capture_i && at_limit;
  assign do_rd    = norm && rd_en_i && (occ_q != '0);

  always_comb begin
    occ_d  = occ_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush_i) begin
      occ_d  = '0;
      wptr_d = '0;
      rptr_d = '0;
    end else if (rsp_load_i) begin
      occ_d  = CNT_W'(RSP_BYTES);
      wptr_d = PTR_W'(RSP_BYTES);
      rptr_d = '0;
    end else begin
      if (do_wr) wptr_d = bump(wptr_q);
      if (do_rd && !dout_phase_i) rptr_d = bump(rptr_q);
      occ_d = occ_q + {{(CNT_W-1){1'b0}}, do_wr} - {{(CNT_W-1){1'b0}}, do_rd};
      if (occ_d == '0) begin
        wptr_d = '0;
        rptr_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      occ_q  <= occ_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      if (drop) ovr_q <= 1'b1;
      irq_q  <= do_rd || (rsp_load_i && !flush_i);
      if (do_rd) rd_q <= dout_phase_i ? 8'h00 : ram_rdata_i;
    end
  end

  assign push_o    = do_wr;
  assign rsp_o     = rsp_load_i && !flush_i;
  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;
  assign occ_o     = occ_q;
  assign rd_data_o = rd_q;
  assign overrun_o = ovr_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LEN_W    = $clog2(CMD_DEPTH + 1),
  localparam int IDX_W    = $clog2(CMD_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_en_i,
  output logic [7:0]       rd_data_o,
  input  logic             capture_i,
  input  logic             dout_phase_i,
  input  logic             rsp_load_i,
  input  logic [7:0]       rsp_status_i,
  input  logic             cmd_fetch_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  output logic [7:0]       cmd_byte_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic [CNT_W-1:0] occupancy_o,
  output logic             overrun_o,
  output logic             irq_o
);
  logic             push, rsp;
  logic [PTR_W-1:0] wptr, rptr;
  byte_t            ram_rdata;

  pio_fifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .capture_i   (capture_i),
    .dout_phase_i(dout_phase_i),
    .rsp_load_i  (rsp_load_i),
    .flush_i     (cmd_fetch_i),
    .ram_rdata_i (ram_rdata),
    .push_o      (push),
    .rsp_o       (rsp),
    .wptr_o      (wptr),
    .rptr_o      (rptr),
    .occ_o       (occupancy_o),
    .rd_data_o   (rd_data_o),
    .overrun_o   (overrun_o),
    .irq_o       (irq_o)
  );

  // port a: host push or status byte; port b: zero message byte
  pio_byte_ram #(.DEPTH(DEPTH), .AW(PTR_W)) u_ram (
    .clk_i   (clk_i),
    .we_a_i  (push || rsp),
    .addr_a_i(rsp ? '0 : wptr),
    .data_a_i(rsp ? rsp_status_i : wr_data_i),
    .we_b_i  (rsp),
    .addr_b_i(PTR_W'(1)),
    .data_b_i(MSG_FILL),
    .raddr_i (rptr),
    .rdata_o (ram_rdata)
  );

  pio_cmd_capture #(.CMD_DEPTH(CMD_DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .capture_i(capture_i),
    .flush_i  (cmd_fetch_i),
    .wr_data_i(wr_data_i),
    .idx_i    (cmd_idx_i),
    .len_o    (cmd_len_o),
    .byte_o   (cmd_byte_o)
  );
endmodule

// File: rtl/pio_byte_fifo_chk.sv
module pio_byte_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  parameter int CNT_W     = 5,
  parameter int LEN_W     = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic             capture_i,
  input logic             rsp_load_i,
  input logic             cmd_fetch_i,
  input logic [LEN_W-1:0] cmd_len_o,
  input logic [CNT_W-1:0] occupancy_o,
  input logic             overrun_o,
  input logic             irq_o
);
  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o <= CNT_W'(DEPTH - 1)); // R2

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rd_en_i || rsp_load_i)); // R3

  AST_CAPTURE_KEEPS_FIFO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && capture_i && !rd_en_i && !rsp_load_i && !cmd_fetch_i)
      |=> $stable(occupancy_o)); // R1

  AST_RSP_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_load_i && !cmd_fetch_i) |=> (occupancy_o == CNT_W'(2))); // R6

  AST_FETCH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fetch_i |=> (occupancy_o == '0 && cmd_len_o == '0 && !irq_o)); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R8

  AST_CMD_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_len_o <= LEN_W'(CMD_DEPTH)); // R9
endmodule

bind pio_byte_fifo pio_byte_fifo_chk #(
  .DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .capture_i  (capture_i),
  .rsp_load_i (rsp_load_i),
  .cmd_fetch_i(cmd_fetch_i),
  .cmd_len_o  (cmd_len_o),
  .occupancy_o(occupancy_o),
  .overrun_o  (overrun_o),
  .irq_o      (irq_o)
);

// File: tb/tb_pio_byte_fifo.sv
`timescale 1ns/1ps
module tb_pio_byte_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, capture = 1'b0, dout_ph = 1'b0;
  logic       rsp_load = 1'b0, fetch = 1'b0;
  logic [7:0] wr_data = '0, rsp_status = '0;
  logic [4:0] cmd_idx = '0;
  logic [7:0] rd_data, cmd_byte;
  logic [5:0] cmd_len;
  logic [4:0] occ;
  logic       overrun, irq;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pio_byte_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .capture_i(capture),
    .dout_phase_i(dout_ph), .rsp_load_i(rsp_load), .rsp_status_i(rsp_status),
    .cmd_fetch_i(fetch), .cmd_idx_i(cmd_idx), .cmd_byte_o(cmd_byte),
    .cmd_len_o(cmd_len), .occupancy_o(occ), .overrun_o(overrun), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns 1 ns after the edge with strobes released
  task automatic cyc(input logic w, input logic r, input logic [7:0] d);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; rsp_load = 0; fetch = 0; dout_ph = 0;
  endtask

  // op: 0 write, 1 read, 2 read+write, 3 response load, 4 capture write
  // fields: op[24:22] din[21:14] occ[13:9] rd[8:1] irq[0]
  localparam logic [24:0] VEC [12] = '{
    {3'd0, 8'h11, 5'd1, 8'h00, 1'b0},
    {3'd0, 8'h22, 5'd2, 8'h00, 1'b0},
    {3'd0, 8'h33, 5'd3, 8'h00, 1'b0},
    {3'd1, 8'h00, 5'd2, 8'h11, 1'b1},
    {3'd2, 8'h44, 5'd2, 8'h22, 1'b1},
    {3'd1, 8'h00, 5'd1, 8'h33, 1'b1},
    {3'd1, 8'h00, 5'd0, 8'h44, 1'b1},
    {3'd1, 8'h00, 5'd0, 8'h44, 1'b0},
    {3'd3, 8'hA5, 5'd2, 8'h44, 1'b1},
    {3'd1, 8'h00, 5'd1, 8'hA5, 1'b1},
    {3'd1, 8'h00, 5'd0, 8'h00, 1'b1},
    {3'd4, 8'h77, 5'd0, 8'h00, 1'b0}
  };

  initial begin : watchdog
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 occ", occ, 0);
    chk("R11 cmd_len", cmd_len, 0);
    chk("R11 rd_data", rd_data, 0);
    chk("R11 irq", irq, 0);
    chk("R11 overrun", overrun, 0);

    // vector table: R2 R3 R6 R10 R1
    for (int i = 0; i < 12; i++) begin
      logic [2:0] op;
      op = VEC[i][24:22];
      case (op)
        3'd0: cyc(1, 0, VEC[i][21:14]);
        3'd1: cyc(0, 1, 8'h00);
        3'd2: cyc(1, 1, VEC[i][21:14]);
        3'd3: begin rsp_status = VEC[i][21:14]; rsp_load = 1; cyc(0, 0, 8'h00); end
        default: begin capture = 1; cyc(1, 0, VEC[i][21:14]); capture = 0; end
      endcase
      chk($sformatf("R2/R3/R6/R10 vec%0d occ", i), occ, int'(VEC[i][13:9]));
      chk($sformatf("R3/R6 vec%0d rd", i), rd_data, int'(VEC[i][8:1]));
      chk($sformatf("R3/R6 vec%0d irq", i), irq, int'(VEC[i][0]));
    end
    @(posedge clk); #1;
    chk("R3 irq single pulse", irq, 0);

    // R4 data-out read, R5 pointer reset at empty
    cyc(1, 0, 8'hA1); cyc(1, 0, 8'hB2); cyc(1, 0, 8'hC3);
    dout_ph = 1; cyc(0, 1, 8'h00);
    chk("R4 dout read data", rd_data, 0);
    chk("R4 dout read occ", occ, 2);
    chk("R4 dout read irq", irq, 1);
    cyc(0, 1, 8'h00);
    chk("R4 read position held", rd_data, 8'hA1);
    cyc(0, 1, 8'h00);
    chk("R5 drained occ", occ, 0);
    cyc(1, 0, 8'hD4); cyc(0, 1, 8'h00);
    chk("R5 fresh byte after empty", rd_data, 8'hD4);

    // R1 R9 capture with fifo holding one byte
    cyc(1, 0, 8'hE5);
    capture = 1;
    for (int i = 0; i < 34; i++) cyc(1, 0, 8'h40 + 8'(i));
    capture = 0;
    chk("R1 occ untouched by capture", occ, 1);
    chk("R9 cmd_len saturates", cmd_len, 32);
    cmd_idx = 5'd0;  #1 chk("R1 cmd byte 0", cmd_byte, 8'h77);
    cmd_idx = 5'd1;  #1 chk("R1 cmd byte 1", cmd_byte, 8'h40);
    cmd_idx = 5'd31; #1 chk("R9 cmd byte 31", cmd_byte, 8'h5E);

    // R7 fetch wins over write and response load
    fetch = 1; rsp_load = 1; rsp_status = 8'h3C; cyc(1, 0, 8'h99);
    chk("R7 occ cleared", occ, 0);
    chk("R7 cmd_len cleared", cmd_len, 0);
    chk("R7 no irq", irq, 0);
    cyc(0, 1, 8'h00);
    chk("R3 empty read no irq", irq, 0);

    // R2 R8 R10 overrun
    for (int i = 0; i < 15; i++) cyc(1, 0, 8'h80 + 8'(i));
    chk("R2 fill to limit", occ, 15);
    chk("R8 no overrun yet", overrun, 0);
    cyc(1, 0, 8'hEE);
    chk("R2 write dropped at limit", occ, 15);
    chk("R8 overrun set", overrun, 1);
    cyc(1, 1, 8'h99);
    chk("R10 rw at limit occ", occ, 14);
    chk("R10 rw at limit data", rd_data, 8'h80);
    cyc(1, 0, 8'h77);
    chk("R2 write accepted below limit", occ, 15);
    for (int i = 0; i < 15; i++) cyc(0, 1, 8'h00);
    chk("R10 drain order last byte", rd_data, 8'h77);
    chk("R2 drained", occ, 0);
    chk("R8 overrun sticky", overrun, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule